// File: doc/BRIEF.md
# Dual-Task Acquisition Window Generator

This block decides, sample by sample, whether incoming video falls inside the acquisition window of a scaler. It keeps a pixel counter and a line counter. The horizontal sync pulse restarts the pixel counter and the vertical sync pulse restarts both counters. Two configuration pages, task A and task B, each describe a rectangular window with a pixel start, a pixel count, a line start and a line count. Each page also carries an enable bit, a source select and a field trigger mask. When a page selects the gapped (expansion) source, only qualified samples advance the pixel counter, and a line is counted only if at least one qualified sample arrived during it.

A mode input chooses how the two pages share the video. In field-alternate mode, the field parity sampled at vertical sync picks the page: parity 0 selects A and parity 1 selects B. In region-split mode, every field starts on A and hands over to B at the first line boundary where A's line range is exhausted. Task changes happen only at sync pulses. The outputs are a registered in-window flag, the active task, and the live counters.

Top module: `acq_window_gen`

## Requirements
- R1: After reset, `win_o` is 0, `task_o` is 0 (task A), and `pix_cnt_o` and `line_cnt_o` are 0.
- R2: For a page with direct source (`xsrc` = 0), every cycle without a sync pulse is a sample and advances `pix_cnt_o` by 1. A cycle with `hsync` set clears `pix_cnt_o`. A cycle with `vsync` set clears both counters.
- R3: For a page with gapped source (`xsrc` = 1), only cycles with `pix_q` = 1 advance `pix_cnt_o`.
- R4: For a gapped-source page, an `hsync` advances `line_cnt_o` only if the line that just ended held at least one sample with `pix_q` = 1. Otherwise `line_cnt_o` keeps its value. For a direct-source page, every `hsync` advances it.
- R5: `win_o` is 1 in the cycle after a valid sample whose pixel index p and line index l satisfy `hstart <= p < hstart+hlen` and `vstart <= l < vstart+vlen` for the active page. A sync cycle is never a valid sample, and neither is an unqualified cycle on a gapped-source page.
- R6: With `region_mode` = 0, a `vsync` selects task A if `field_in` = 0 and task B if `field_in` = 1. The new task is visible on `task_o` in the next cycle.
- R7: With `region_mode` = 1, a `vsync` selects task A. An `hsync` that moves the line index to a value at or above A's `vstart + vlen` while A is active selects task B.
- R8: `task_o` changes only in the cycle after a `vsync` or `hsync`, never in the middle of a line.
- R9: A page whose enable bit is 0 never causes `win_o` = 1.
- R10: Each page's trigger mask gates its window by field parity. Mask bit 0 allows the field latched with `field_in` = 0, and mask bit 1 allows the field latched with `field_in` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Line-start pulse |
| vsync | input | 1 | Field-start pulse, dominates hsync |
| field_in | input | 1 | Field parity, sampled at vsync |
| pix_q | input | 1 | Sample qualifier for gapped sources |
| region_mode | input | 1 | 0 = field alternate, 1 = region split |
| cfg_a_en | input | 1 | Task A enable |
| cfg_a_xsrc | input | 1 | Task A gapped-source select |
| cfg_a_trig | input | 2 | Task A field trigger mask |
| cfg_a_hstart | input | 12 | Task A first pixel |
| cfg_a_hlen | input | 12 | Task A pixel count |
| cfg_a_vstart | input | 12 | Task A first line |
| cfg_a_vlen | input | 12 | Task A line count |
| cfg_b_en | input | 1 | Task B enable |
| cfg_b_xsrc | input | 1 | Task B gapped-source select |
| cfg_b_trig | input | 2 | Task B field trigger mask |
| cfg_b_hstart | input | 12 | Task B first pixel |
| cfg_b_hlen | input | 12 | Task B pixel count |
| cfg_b_vstart | input | 12 | Task B first line |
| cfg_b_vlen | input | 12 | Task B line count |
| win_o | output | 1 | Registered in-window flag |
| task_o | output | 1 | Active task (0 = A, 1 = B) |
| pix_cnt_o | output | 12 | Pixel counter |
| line_cnt_o | output | 12 | Line counter |

## Verification
The bench drives gapped streams with alternating and absent qualifiers. A design that counted every cycle would open the window on the wrong samples, and one that counted empty lines would step `line_cnt_o` past a line with no qualified samples. It checks the exclusive end of both ranges and the region hand-over at exactly A's last line plus one; an off-by-one there would leave B late or start it one line early. It also checks disabled pages and blocking trigger masks against windows that would otherwise fire. A design that ignored either one would raise `win_o`.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned NPAGE = 2;
  typedef enum logic {TASK_A = 1'b0, TASK_B = 1'b1} task_e;
endpackage

// File: rtl/acq_counters.sv
module acq_counters #(
  parameter int unsigned W = acq_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hsync,
  input  logic         vsync,
  input  logic         pix_q,
  input  logic         xsrc,
  output logic [W-1:0] pcnt,
  output logic [W-1:0] lcnt,
  output logic [W-1:0] lcnt_nxt,
  output logic         smp_valid
);
  localparam logic [W-1:0] MAXV = '1;

  logic seen;
  logic cnt_en;
  logic line_counts;

  assign cnt_en      = xsrc ? pix_q : 1'b1;
  assign smp_valid   = cnt_en & ~hsync & ~vsync;
  assign line_counts = xsrc ? seen : 1'b1;
  assign lcnt_nxt    = (line_counts && lcnt != MAXV) ? lcnt + 1'b1 : lcnt;

  always_ff @(posedge clk) begin
    if (rst || vsync) begin
      pcnt <= '0;
      lcnt <= '0;
      seen <= 1'b0;
    end else if (hsync) begin
      pcnt <= '0;
      lcnt <= lcnt_nxt;
      seen <= 1'b0;
    end else if (cnt_en) begin
      if (pcnt != MAXV) pcnt <= pcnt + 1'b1;
      seen <= 1'b1;
    end
  end

  AST_PIX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (hsync || vsync) |=> (pcnt == '0)); // R2
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hsync && !vsync && xsrc && !pix_q) |=> $stable(pcnt)); // R3
  AST_EMPTY_LINE: assert property (@(posedge clk) disable iff (rst)
    (hsync && !vsync && xsrc && !seen) |=> $stable(lcnt)); // R4
endmodule

// File: rtl/acq_span_cmp.sv
module acq_span_cmp #(
  parameter int unsigned W = acq_pkg::CNT_W
) (
  input  logic         en,
  input  logic [1:0]   trig,
  input  logic         field,
  input  logic [W-1:0] pcnt,
  input  logic [W-1:0] lcnt,
  input  logic [W-1:0] hstart,
  input  logic [W-1:0] hlen,
  input  logic [W-1:0] vstart,
  input  logic [W-1:0] vlen,
  output logic         hit
);
  logic [W:0] hend;
  logic [W:0] vend;
  logic       h_in;
  logic       v_in;

  assign hend = {1'b0, hstart} + {1'b0, hlen};
  assign vend = {1'b0, vstart} + {1'b0, vlen};
  assign h_in = (pcnt >= hstart) && ({1'b0, pcnt} < hend);
  assign v_in = (lcnt >= vstart) && ({1'b0, lcnt} < vend);
  assign hit  = en & trig[field] & h_in & v_in;
endmodule

// File: rtl/acq_task_sel.sv
module acq_task_sel #(
  parameter int unsigned W = acq_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          field_in,
  input  logic          region_mode,
  input  logic [W-1:0]  a_vstart,
  input  logic [W-1:0]  a_vlen,
  input  logic [W-1:0]  lcnt_nxt,
  output acq_pkg::task_e task_q,
  output logic          field_q
);
  import acq_pkg::*;

  logic [W:0] a_vend;
  logic       a_done;

  assign a_vend = {1'b0, a_vstart} + {1'b0, a_vlen};
  assign a_done = ({1'b0, lcnt_nxt} >= a_vend);

  always_ff @(posedge clk) begin
    if (rst) begin
      task_q  <= TASK_A;
      field_q <= 1'b0;
    end else if (vsync) begin
      field_q <= field_in;
      if (region_mode)   task_q <= TASK_A;
      else if (field_in) task_q <= TASK_B;
      else               task_q <= TASK_A;
    end else if (hsync && region_mode && task_q == TASK_A && a_done) begin
      task_q <= TASK_B;
    end
  end

  AST_NO_MIDLINE_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (!hsync && !vsync) |=> $stable(task_q)); // R8
  AST_FIELD_ALT: assert property (@(posedge clk) disable iff (rst)
    (vsync && !region_mode) |=> (task_q == task_e'($past(field_in)))); // R6
  AST_REGION_START: assert property (@(posedge clk) disable iff (rst)
    (vsync && region_mode) |=> (task_q == TASK_A)); // R7
endmodule

// File: rtl/acq_window_gen.sv
module acq_window_gen #(
  parameter int unsigned W     = acq_pkg::CNT_W,
  parameter int unsigned NPAGE = acq_pkg::NPAGE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hsync,
  input  logic         vsync,
  input  logic         field_in,
  input  logic         pix_q,
  input  logic         region_mode,
  input  logic         cfg_a_en,
  input  logic         cfg_a_xsrc,
  input  logic [1:0]   cfg_a_trig,
  input  logic [W-1:0] cfg_a_hstart,
  input  logic [W-1:0] cfg_a_hlen,
  input  logic [W-1:0] cfg_a_vstart,
  input  logic [W-1:0] cfg_a_vlen,
  input  logic         cfg_b_en,
  input  logic         cfg_b_xsrc,
  input  logic [1:0]   cfg_b_trig,
  input  logic [W-1:0] cfg_b_hstart,
  input  logic [W-1:0] cfg_b_hlen,
  input  logic [W-1:0] cfg_b_vstart,
  input  logic [W-1:0] cfg_b_vlen,
  output logic         win_o,
  output logic         task_o,
  output logic [W-1:0] pix_cnt_o,
  output logic [W-1:0] line_cnt_o
);
  import acq_pkg::*;

  logic [NPAGE-1:0]             pg_en;
  logic [NPAGE-1:0]             pg_xsrc;
  logic [NPAGE-1:0][1:0]        pg_trig;
  logic [NPAGE-1:0][W-1:0]      pg_hs;
  logic [NPAGE-1:0][W-1:0]      pg_hl;
  logic [NPAGE-1:0][W-1:0]      pg_vs;
  logic [NPAGE-1:0][W-1:0]      pg_vl;
  logic [NPAGE-1:0]             hit_vec;

  assign pg_en   = {cfg_b_en, cfg_a_en};
  assign pg_xsrc = {cfg_b_xsrc, cfg_a_xsrc};
  assign pg_trig = {cfg_b_trig, cfg_a_trig};
  assign pg_hs   = {cfg_b_hstart, cfg_a_hstart};
  assign pg_hl   = {cfg_b_hlen, cfg_a_hlen};
  assign pg_vs   = {cfg_b_vstart, cfg_a_vstart};
  assign pg_vl   = {cfg_b_vlen, cfg_a_vlen};

  task_e       task_q;
  logic        act;
  logic        field_q;
  logic [W-1:0] pcnt;
  logic [W-1:0] lcnt;
  logic [W-1:0] lcnt_nxt;
  logic        smp_valid;
  logic        win_d;
  logic        act_en;

  assign act    = task_q;
  assign act_en = pg_en[act];

  acq_counters #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .pix_q(pix_q),
    .xsrc(pg_xsrc[act]), .pcnt(pcnt), .lcnt(lcnt), .lcnt_nxt(lcnt_nxt),
    .smp_valid(smp_valid)
  );

  acq_task_sel #(.W(W)) u_sel (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .field_in(field_in),
    .region_mode(region_mode), .a_vstart(cfg_a_vstart), .a_vlen(cfg_a_vlen),
    .lcnt_nxt(lcnt_nxt), .task_q(task_q), .field_q(field_q)
  );

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    acq_span_cmp #(.W(W)) u_cmp (
      .en(pg_en[p]), .trig(pg_trig[p]), .field(field_q),
      .pcnt(pcnt), .lcnt(lcnt),
      .hstart(pg_hs[p]), .hlen(pg_hl[p]), .vstart(pg_vs[p]), .vlen(pg_vl[p]),
      .hit(hit_vec[p])
    );
  end

  assign win_d = hit_vec[act] & smp_valid;

  always_ff @(posedge clk) begin
    if (rst) win_o <= 1'b0;
    else     win_o <= win_d;
  end

  assign task_o     = act;
  assign pix_cnt_o  = pcnt;
  assign line_cnt_o = lcnt;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !act_en |=> !win_o); // R9
  AST_SYNC_NO_WIN: assert property (@(posedge clk) disable iff (rst)
    (hsync || vsync) |=> !win_o); // R5
  AST_TRIG_GATE: assert property (@(posedge clk) disable iff (rst)
    !pg_trig[act][field_q] |=> !win_o); // R10
endmodule

// File: tb/acq_window_gen_bench.sv
module acq_window_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync = 1'b0, vsync = 1'b0, field_in = 1'b0, pix_q = 1'b0, region_mode = 1'b0;
  logic cfg_a_en = 1'b0, cfg_a_xsrc = 1'b0, cfg_b_en = 1'b0, cfg_b_xsrc = 1'b0;
  logic [1:0] cfg_a_trig = 2'b11, cfg_b_trig = 2'b11;
  logic [W-1:0] cfg_a_hstart = '0, cfg_a_hlen = '0, cfg_a_vstart = '0, cfg_a_vlen = '0;
  logic [W-1:0] cfg_b_hstart = '0, cfg_b_hlen = '0, cfg_b_vstart = '0, cfg_b_vlen = '0;
  logic win_o, task_o;
  logic [W-1:0] pix_cnt_o, line_cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_window_gen u_acq_window_gen (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .field_in(field_in),
    .pix_q(pix_q), .region_mode(region_mode),
    .cfg_a_en(cfg_a_en), .cfg_a_xsrc(cfg_a_xsrc), .cfg_a_trig(cfg_a_trig),
    .cfg_a_hstart(cfg_a_hstart), .cfg_a_hlen(cfg_a_hlen),
    .cfg_a_vstart(cfg_a_vstart), .cfg_a_vlen(cfg_a_vlen),
    .cfg_b_en(cfg_b_en), .cfg_b_xsrc(cfg_b_xsrc), .cfg_b_trig(cfg_b_trig),
    .cfg_b_hstart(cfg_b_hstart), .cfg_b_hlen(cfg_b_hlen),
    .cfg_b_vstart(cfg_b_vstart), .cfg_b_vlen(cfg_b_vlen),
    .win_o(win_o), .task_o(task_o), .pix_cnt_o(pix_cnt_o), .line_cnt_o(line_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit hs, input bit vs, input bit q);
    hsync = hs; vsync = vs; pix_q = q;
    @(posedge clk);
    @(negedge clk);
  endtask

  // qmode: 0 all qualified, 1 alternating starting unqualified, 2 none
  task automatic scan_line(input int n, input int qmode, input bit xs,
                           input int hs, input int hl, input bit line_in,
                           input string req);
    int k = 0;
    for (int i = 0; i < n; i++) begin
      bit q;
      bit valid;
      bit ew;
      q = (qmode == 0) ? 1'b1 : (qmode == 1) ? bit'(i % 2) : 1'b0;
      step(1'b0, 1'b0, q);
      valid = xs ? q : 1'b1;
      ew = valid && line_in && (k >= hs) && (k < hs + hl);
      if (valid) k++;
      chk({req, " win"}, int'(win_o), int'(ew));
      chk({req, " pix"}, int'(pix_cnt_o), k);
    end
  endtask

  task automatic set_a(input bit en, input bit xs, input bit [1:0] tr,
                       input int hs, input int hl, input int vs, input int vl);
    cfg_a_en = en; cfg_a_xsrc = xs; cfg_a_trig = tr;
    cfg_a_hstart = W'(hs); cfg_a_hlen = W'(hl); cfg_a_vstart = W'(vs); cfg_a_vlen = W'(vl);
  endtask

  task automatic set_b(input bit en, input bit xs, input bit [1:0] tr,
                       input int hs, input int hl, input int vs, input int vl);
    cfg_b_en = en; cfg_b_xsrc = xs; cfg_b_trig = tr;
    cfg_b_hstart = W'(hs); cfg_b_hlen = W'(hl); cfg_b_vstart = W'(vs); cfg_b_vlen = W'(vl);
  endtask

  task automatic t_reset();
    chk("R1 win", int'(win_o), 0);
    chk("R1 task", int'(task_o), 0);
    chk("R1 pix", int'(pix_cnt_o), 0);
    chk("R1 line", int'(line_cnt_o), 0);
  endtask

  task automatic t_direct();
    region_mode = 1'b0; field_in = 1'b0;
    set_a(1, 0, 2'b11, 3, 4, 1, 2);
    set_b(0, 0, 2'b11, 0, 0, 0, 0);
    step(0, 1, 0);
    chk("R2 vsync pix", int'(pix_cnt_o), 0);
    chk("R2 vsync line", int'(line_cnt_o), 0);
    scan_line(10, 0, 0, 3, 4, 0, "R2/R5 line0");
    step(1, 0, 0);
    chk("R2 hsync pix", int'(pix_cnt_o), 0);
    chk("R2 hsync line", int'(line_cnt_o), 1);
    chk("R5 sync no win", int'(win_o), 0);
    scan_line(10, 0, 0, 3, 4, 1, "R5 line1");
    step(1, 0, 0);
    scan_line(8, 0, 0, 3, 4, 1, "R5 line2");
    step(1, 0, 0);
    chk("R4 direct line", int'(line_cnt_o), 3);
    scan_line(8, 0, 0, 3, 4, 0, "R5 line3 end");
  endtask

  task automatic t_gapped();
    region_mode = 1'b0; field_in = 1'b0;
    set_a(1, 1, 2'b11, 1, 2, 0, 1);
    step(0, 1, 0);
    scan_line(6, 1, 1, 1, 2, 1, "R3/R5 gapped");
    chk("R3 pix total", int'(pix_cnt_o), 3);
    step(1, 0, 0);
    chk("R4 line qualified", int'(line_cnt_o), 1);
    scan_line(4, 2, 1, 1, 2, 0, "R3 empty");
    step(1, 0, 0);
    chk("R4 empty line held", int'(line_cnt_o), 1);
    scan_line(2, 0, 1, 1, 2, 0, "R3 full");
    step(1, 0, 0);
    chk("R4 line after q", int'(line_cnt_o), 2);
  endtask

  task automatic t_field_alt();
    region_mode = 1'b0;
    set_a(1, 0, 2'b11, 0, 1, 0, 1);
    set_b(1, 0, 2'b11, 1, 1, 0, 1);
    field_in = 1'b1;
    step(0, 1, 0);
    chk("R6 field1 task B", int'(task_o), 1);
    scan_line(3, 0, 0, 1, 1, 1, "R6 B window");
    chk("R8 task stable", int'(task_o), 1);
    field_in = 1'b0;
    step(0, 1, 0);
    chk("R6 field0 task A", int'(task_o), 0);
    scan_line(3, 0, 0, 0, 1, 1, "R6 A window");
  endtask

  task automatic t_region();
    region_mode = 1'b1; field_in = 1'b1;
    set_a(1, 0, 2'b11, 0, 2, 0, 2);
    set_b(1, 0, 2'b11, 0, 2, 3, 1);
    step(0, 1, 0);
    chk("R7 region start A", int'(task_o), 0);
    scan_line(3, 0, 0, 0, 2, 1, "R7 A line0");
    step(1, 0, 0);
    chk("R7 still A line1", int'(task_o), 0);
    scan_line(3, 0, 0, 0, 2, 1, "R7 A line1");
    chk("R8 no midline switch", int'(task_o), 0);
    step(1, 0, 0);
    chk("R7 switch to B", int'(task_o), 1);
    chk("R7 line at switch", int'(line_cnt_o), 2);
    scan_line(3, 0, 0, 0, 2, 0, "R7 B line2 outside");
    step(1, 0, 0);
    scan_line(3, 0, 0, 0, 2, 1, "R7 B line3 inside");
    step(0, 1, 0);
    chk("R7 back to A", int'(task_o), 0);
  endtask

  task automatic t_disabled();
    region_mode = 1'b0; field_in = 1'b0;
    set_a(0, 0, 2'b11, 0, 100, 0, 100);
    step(0, 1, 0);
    scan_line(5, 0, 0, 0, 0, 0, "R9 disabled A");
    step(1, 0, 0);
    scan_line(5, 0, 0, 0, 0, 0, "R9 disabled A line1");
  endtask

  task automatic t_trig();
    region_mode = 1'b1; field_in = 1'b1;
    set_a(1, 0, 2'b01, 0, 4, 0, 4);
    step(0, 1, 0);
    scan_line(3, 0, 0, 0, 4, 0, "R10 mask blocks field1");
    cfg_a_trig = 2'b10;
    step(0, 1, 0);
    scan_line(3, 0, 0, 0, 4, 1, "R10 mask allows field1");
    field_in = 1'b0;
    step(0, 1, 0);
    scan_line(3, 0, 0, 0, 4, 0, "R10 mask blocks field0");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(0, 0, 0);
    step(0, 0, 0);
    rst = 1'b0;
    t_reset();
    t_direct();
    t_gapped();
    t_field_alt();
    t_region();
    t_disabled();
    t_trig();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule